// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Gate

This block gathers the three fault sources of a small 8-bit computer that may stop the processor with a non-maskable interrupt, and drives the single NMI line. The three sources are a numeric coprocessor error level, a memory parity error pulse and an expansion channel check level. The parity and channel sources each pass through a sticky latch. Each latch is armed by its own enable bit, which comes from a system output port. Clearing that enable bit also empties the latch. Both latch states are brought out so that a system input port can show them to software.

A master enable bit gates the whole output. Software sets or clears it with an I/O write to a 32-byte window of the I/O space. Only bit 7 of the written byte is stored, and writes that occur during DMA cycles do nothing. Software therefore sees each error through the input port and acknowledges it by dropping and then raising the matching enable bit.

Top module: `nmi_gate_top`

## Requirements
- R1: After a synchronous reset, the master enable, both latches, `nmi`, `parity_flag` and `chan_flag` are all 0.
- R2: A cycle with `io_wr`=1, `dma_cycle`=0 and an address in the window loads `wr_data[7]` into the master enable. The new value takes effect on `nmi` from the next cycle. The window is 10-bit addresses 0x0A0 to 0x0BF.
- R3: Address bits 4:0 are not decoded, so every address from 0x0A0 through 0x0BF reaches the register. Addresses outside the window, such as 0x09F, 0x0C0 and 0x2B5, leave the master enable unchanged.
- R4: A write in the window while `dma_cycle`=1 leaves the master enable unchanged.
- R5: When `parity_en`=1 and `parity_err`=1 at a clock edge, the parity latch sets. `parity_flag` is 1 from the next cycle and stays 1 after the pulse ends, for as long as `parity_en` stays 1.
- R6: An error that arrives while its own enable is 0 does not set its latch.
- R7: While an enable is 0 at a clock edge, its latch is cleared, and the matching flag reads 0 from the next cycle.
- R8: The channel latch follows the same set and hold rules through `chan_chk` and `chan_en`, and is shown on `chan_flag`.
- R9: `nmi` = master enable AND (`copro_err` OR parity latch OR channel latch). The `copro_err` path has no register, so `nmi` follows it in the same cycle.
- R10: While the master enable is 0, `nmi` stays 0 even when a latch is set or `copro_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 10 | I/O address of the current bus cycle |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| dma_cycle | input | 1 | High while the bus is driven by DMA |
| wr_data | input | 8 | Write data; bit 7 is the master enable |
| copro_err | input | 1 | Coprocessor error level |
| parity_err | input | 1 | Memory parity error pulse |
| chan_chk | input | 1 | Expansion channel check level |
| parity_en | input | 1 | Parity latch enable (0 clears the latch) |
| chan_en | input | 1 | Channel latch enable (0 clears the latch) |
| nmi | output | 1 | Non-maskable interrupt to the processor |
| parity_flag | output | 1 | Parity latch state for the input port |
| chan_flag | output | 1 | Channel latch state for the input port |

## Verification
Register writes and latch set or clear events appear on the outputs one clock after the edge that captures them. A change on `copro_err` reaches `nmi` in the same cycle, with no edge in between. The bench drives inputs just after each falling edge and keeps a behavioural model that it updates on the rising edge. It compares all three outputs at every falling edge, which is half a cycle after any registered change has settled. The directed checks use the same rule: they sample one full cycle after the stimulus for registered results, and 1 ns after the input change for the `copro_err` path.

// File: rtl/nmi_gate_pkg.sv
package nmi_gate_pkg;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 8;
    localparam int SEL_LSB    = 5;
    localparam int MASTER_BIT = 7;
    localparam int NUM_LATCH  = 2;
    localparam logic [ADDR_W-1:0] REG_BASE = 10'h0A0;

    typedef enum int {LAT_PARITY = 0, LAT_CHAN = 1} latch_idx_e;

    typedef struct packed {
        logic chan;
        logic parity;
    } err_flags_t;

    function automatic logic window_hit(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:SEL_LSB] == REG_BASE[ADDR_W-1:SEL_LSB];
    endfunction
endpackage

// File: rtl/nmi_master_reg.sv
module nmi_master_reg
    import nmi_gate_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int BIT = MASTER_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          dma_cycle,
    input  logic [DW-1:0] wr_data,
    output logic          master_en
);
    logic wr_hit;
    logic unused_data;

    assign wr_hit      = io_wr && !dma_cycle && window_hit(io_addr);
    assign unused_data = ^wr_data;

    always_ff @(posedge clk) begin
        if (rst)
            master_en <= 1'b0;
        else if (wr_hit)
            master_en <= wr_data[BIT];
    end

    // R2
    master_load_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !dma_cycle && io_addr >= 10'h0A0 && io_addr <= 10'h0BF)
        |=> master_en == $past(wr_data[BIT]));

    // R4
    dma_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr && dma_cycle) |=> $stable(master_en));
endmodule

// File: rtl/nmi_err_latch.sv
module nmi_err_latch (
    input  logic clk,
    input  logic rst,
    input  logic err,
    input  logic en,
    output logic held
);
    always_ff @(posedge clk) begin
        if (rst || !en)
            held <= 1'b0;
        else if (err)
            held <= 1'b1;
    end

    // R5
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (en && err) |=> held);

    // R7
    latch_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !held);

    // R6
    latch_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!held && !err) |=> !held);
endmodule

// File: rtl/nmi_gate_top.sv
module nmi_gate_top
    import nmi_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              dma_cycle,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              copro_err,
    input  logic              parity_err,
    input  logic              chan_chk,
    input  logic              parity_en,
    input  logic              chan_en,
    output logic              nmi,
    output logic              parity_flag,
    output logic              chan_flag
);
    logic                 master_en;
    logic [NUM_LATCH-1:0] err_vec;
    logic [NUM_LATCH-1:0] en_vec;
    logic [NUM_LATCH-1:0] held_vec;
    err_flags_t           flags;

    nmi_master_reg #(
        .AW(ADDR_W), .DW(DATA_W), .BIT(MASTER_BIT)
    ) i_master (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .dma_cycle(dma_cycle), .wr_data(wr_data), .master_en(master_en)
    );

    assign err_vec[LAT_PARITY] = parity_err;
    assign err_vec[LAT_CHAN]   = chan_chk;
    assign en_vec[LAT_PARITY]  = parity_en;
    assign en_vec[LAT_CHAN]    = chan_en;

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_lat
        nmi_err_latch i_lat (
            .clk(clk), .rst(rst), .err(err_vec[g]),
            .en(en_vec[g]), .held(held_vec[g])
        );
    end

    assign flags.parity = held_vec[LAT_PARITY];
    assign flags.chan   = held_vec[LAT_CHAN];

    assign parity_flag = flags.parity;
    assign chan_flag   = flags.chan;
    assign nmi         = master_en && (copro_err || (|held_vec));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> !nmi);

    // R9
    copro_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (master_en && copro_err) |-> nmi);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!nmi && !parity_flag && !chan_flag));
endmodule

// File: tb/test_nmi_gate_top.sv
`timescale 1ns/1ps
module test_nmi_gate_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] io_addr = '0;
    logic       io_wr = 1'b0, dma_cycle = 1'b0;
    logic [7:0] wr_data = '0;
    logic       copro_err = 1'b0, parity_err = 1'b0, chan_chk = 1'b0;
    logic       parity_en = 1'b0, chan_en = 1'b0;
    logic       nmi, parity_flag, chan_flag;

    int    n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    bit m_master = 0, m_par = 0, m_chan = 0;

    always #5 clk = ~clk;

    nmi_gate_top i_nmi_gate_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .dma_cycle(dma_cycle), .wr_data(wr_data), .copro_err(copro_err),
        .parity_err(parity_err), .chan_chk(chan_chk), .parity_en(parity_en),
        .chan_en(chan_en), .nmi(nmi), .parity_flag(parity_flag), .chan_flag(chan_flag)
    );

    // behavioural reference, updated on the rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_master = 0; m_par = 0; m_chan = 0;
        end else begin
            if (io_wr && !dma_cycle && io_addr >= 10'd160 && io_addr <= 10'd191)
                m_master = wr_data[7];
            m_par  = parity_en ? (m_par  | parity_err) : 1'b0;
            m_chan = chan_en   ? (m_chan | chan_chk)   : 1'b0;
        end
    end

    function automatic bit exp_nmi();
        return m_master & (copro_err | m_par | m_chan);
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) if (!done) begin
        check(cur_req, "nmi(model)",         nmi,         exp_nmi());
        check(cur_req, "parity_flag(model)", parity_flag, m_par);
        check(cur_req, "chan_flag(model)",   chan_flag,   m_chan);
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [9:0] a, logic [7:0] d, logic dma);
        io_addr = a; wr_data = d; dma_cycle = dma; io_wr = 1'b1;
        cyc();
        io_wr = 1'b0; dma_cycle = 1'b0;
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 5000) begin @(posedge clk); wd++; end
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R1 reset state
        check("R1", "nmi", nmi, 1'b0);
        check("R1", "parity_flag", parity_flag, 1'b0);
        check("R1", "chan_flag", chan_flag, 1'b0);
        rst = 1'b0;
        cyc();

        // R5 parity latch set and hold, master still off (R10)
        cur_req = "R5";
        parity_en = 1'b1; parity_err = 1'b1; cyc(); parity_err = 1'b0;
        check("R5", "parity_flag set", parity_flag, 1'b1);
        cyc(3);
        check("R5", "parity_flag hold", parity_flag, 1'b1);
        check("R10", "nmi masked with latch", nmi, 1'b0);

        // R2 master enable write
        cur_req = "R2";
        wr(10'h0A0, 8'h80, 1'b0);
        check("R2", "nmi after enable", nmi, 1'b1);

        // R7 clear by dropping enable
        cur_req = "R7";
        parity_en = 1'b0; cyc();
        check("R7", "parity_flag cleared", parity_flag, 1'b0);
        check("R7", "nmi after clear", nmi, 1'b0);

        // R9 coprocessor path, same cycle
        cur_req = "R9";
        copro_err = 1'b1; #1;
        check("R9", "nmi follows copro", nmi, 1'b1);
        cyc(); copro_err = 1'b0; #1;
        check("R9", "nmi drops with copro", nmi, 1'b0);

        // R3 address window edges and out-of-window addresses
        cur_req = "R3";
        wr(10'h0BF, 8'h00, 1'b0);
        copro_err = 1'b1; #1;
        check("R3", "top of window disables", nmi, 1'b0);
        wr(10'h0C0, 8'h80, 1'b0);
        check("R3", "0x0C0 ignored", nmi, 1'b0);
        wr(10'h09F, 8'h80, 1'b0);
        check("R3", "0x09F ignored", nmi, 1'b0);
        wr(10'h2B5, 8'h80, 1'b0);
        check("R3", "0x2B5 ignored", nmi, 1'b0);
        wr(10'h0B3, 8'h7F, 1'b0);
        check("R2", "only bit 7 counts", nmi, 1'b0);
        wr(10'h0AD, 8'h80, 1'b0);
        check("R3", "mid window enables", nmi, 1'b1);

        // R4 DMA cycle write ignored
        cur_req = "R4";
        wr(10'h0A5, 8'h00, 1'b1);
        check("R4", "dma write ignored", nmi, 1'b1);
        copro_err = 1'b0; cyc();

        // R6 errors with enables low
        cur_req = "R6";
        parity_err = 1'b1; chan_chk = 1'b1; cyc(); parity_err = 1'b0;
        cyc();
        check("R6", "parity_flag stays 0", parity_flag, 1'b0);
        check("R6", "chan_flag stays 0", chan_flag, 1'b0);
        check("R6", "nmi stays 0", nmi, 1'b0);

        // R8 channel latch
        cur_req = "R8";
        chan_en = 1'b1; cyc();
        check("R8", "chan_flag set", chan_flag, 1'b1);
        check("R8", "nmi from channel", nmi, 1'b1);
        chan_chk = 1'b0; cyc(2);
        check("R8", "chan_flag hold", chan_flag, 1'b1);
        chan_en = 1'b0; cyc();
        check("R7", "chan_flag cleared", chan_flag, 1'b0);

        // R10 master off with channel latch and coprocessor error
        cur_req = "R10";
        wr(10'h0B0, 8'h00, 1'b0);
        chan_en = 1'b1; chan_chk = 1'b1; copro_err = 1'b1; cyc(2);
        check("R10", "chan_flag latched", chan_flag, 1'b1);
        check("R10", "nmi masked", nmi, 1'b0);
        chan_chk = 1'b0; copro_err = 1'b0;

        // R1 reset mid-run clears state
        cur_req = "R1";
        rst = 1'b1; cyc();
        check("R1", "chan_flag after reset", chan_flag, 1'b0);
        rst = 1'b0; chan_en = 1'b0; cyc(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule